// File: doc/BRIEF.md
# Indirect Parameter RAM Access Port

This block lets a host reach a private parameter memory through just two bus-visible registers. The host first writes a control word that may load a word pointer and that selects the transfer direction and whether the pointer steps on its own. Each access to the data register then moves one word between the bus and the memory. When stepping is enabled, a run of data accesses covers consecutive words without another control write.

The memory holds one fixed-size region per input channel: 10 channels of 16 words each, 160 words of 32 bits in all. After each data transfer the port is busy for a short fixed time. The host polls the busy flag in the control register and waits for it to clear before it issues the next command. Data-register accesses change state, so the host never issues them speculatively.

The host side is a valid/ready register bus. It carries a 2-bit register index and 32-bit write data, and each read is answered one cycle after it is accepted.

Top module: `param_ram_port`

## Requirements
- R1: While reset is held, `req_ready_o` and `rsp_valid_o` are low. One cycle after reset is released, `req_ready_o` is high and a control read returns 0x00004000 (write direction, stepping off, pointer 0, not busy).
- R2: The control word has this layout. Bit 31 is busy and is read-only; writing it has no effect. Bit 14 is the direction (1 = write, 0 = read). Bit 13 is the pointer-load strobe and always reads 0. Bit 12 enables stepping. Bits 7:0 carry the pointer.
- R3: A control write with bit 13 set loads the pointer from bits 7:0. A control write with bit 13 clear leaves the pointer unchanged and updates only the direction and stepping bits.
- R4: In write direction, a data-register write stores its word at the current pointer.
- R5: In read direction, a data-register read returns the word at the current pointer.
- R6: With stepping on, each effective data access advances the pointer by one, and the pointer wraps from 159 to 0. With stepping off, the pointer stays where it is.
- R7: An effective data access raises busy for exactly 2 cycles. Requests accepted in the next two cycles see busy set; the request accepted in the third cycle sees it clear.
- R8: While busy is set, control writes are ignored and so are data accesses. An ignored data write is not stored. An ignored data read returns 0. Neither one moves the pointer or restarts busy.
- R9: A data access whose direction does not match bit 14 has no effect. Such a write is not stored, such a read returns 0, the pointer does not move and busy is not raised.
- R10: When the pointer is 160 or above, a data write is dropped and a data read returns 0. The stepping rule then moves the pointer to 0.
- R11: Register index 0 is control and index 1 is data. Indices 2 and 3 read as 0 and ignore writes. Every accepted read is answered with `rsp_valid_o` high for exactly the next cycle; writes produce no response.
- R12: The word for channel c, slot s is at pointer c*16+s, and words in different channel regions do not alias one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Port accepts a request |
| req_write_i | input | 1 | 1 = register write, 0 = register read |
| req_addr_i | input | 2 | Register index (0 control, 1 data) |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read response valid, one cycle after the read is accepted |
| rsp_rdata_o | output | 32 | Read response data |

## Verification
The bench issues back-to-back commands inside the busy window. A design that does not block control writes would jump to the newly written pointer. One that restarts the busy count on a blocked access would still report busy in the third cycle. One that serves a blocked read would return data and advance the pointer. The bench also steps the pointer from 159 and from an out-of-range value, where a design that wraps at a power of two or stores the word anyway would read back the wrong pointer or a corrupted word. It also performs data accesses in the wrong direction and writes with bit 31 set, where a design that honoured them would change memory contents or report a phantom busy flag.

// File: rtl/param_port_pkg.sv
package param_port_pkg;

    localparam int unsigned WORD_W = 32;

    localparam int unsigned CTRL_BUSY_BIT = 31;
    localparam int unsigned CTRL_WDIR_BIT = 14;
    localparam int unsigned CTRL_LOAD_BIT = 13;
    localparam int unsigned CTRL_STEP_BIT = 12;

    localparam logic [WORD_W-1:0] CTRL_RESET_VAL = 32'h0000_4000;

    localparam int unsigned REG_IDX_W = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_CTRL = 2'd0,
        REG_DATA = 2'd1,
        REG_RSV2 = 2'd2,
        REG_RSV3 = 2'd3
    } reg_idx_e;

    // Registered state of the host-facing port logic.
    typedef struct packed {
        logic              wdir;
        logic              step;
        logic              ready;
        logic              rsp_valid;
        logic              rsp_from_ram;
        logic [WORD_W-1:0] rsp_reg;
    } port_state_t;

endpackage

// File: rtl/param_busy_timer.sv
module param_busy_timer #(
    parameter int unsigned CYCLES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

    // R7: a started transfer is reported busy in the following cycle
    assert_busy_after_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> busy_o);

    // R7: busy never appears without a start
    assert_no_spurious_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !busy_o) |=> !busy_o);

endmodule

// File: rtl/param_ptr_seq.sv
module param_ptr_seq #(
    parameter int unsigned DEPTH  = 160,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] ptr_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d = load_addr_i;
        end else if (step_i) begin
            // out-of-range or last word both wrap to the first word
            ptr_d = (ptr_q >= LAST) ? '0 : ptr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o = ptr_q;

    // R3: load and step are never requested together by the port logic
    assert_load_step_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(load_i && step_i));

endmodule

// File: rtl/param_cfg_ram.sv
module param_cfg_ram #(
    parameter int unsigned DEPTH  = 160,
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  rdata_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    // Storage array carries no reset; only the read register does.
    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (re_i) begin
            rdata_q <= mem_q[addr_i];
        end
    end

    assign rdata_o = rdata_q;

    // R9: one direction per cycle reaches the array
    assert_single_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(we_i && re_i));

    // R10: the array is only touched inside its range
    assert_addr_in_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i || re_i) |-> (int'(addr_i) < DEPTH));

endmodule

// File: rtl/param_ram_port.sv
module param_ram_port
    import param_port_pkg::*;
#(
    parameter int unsigned CHANNELS    = 10,
    parameter int unsigned CH_STRIDE   = 16,
    parameter int unsigned BUSY_CYCLES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 req_valid_i,
    output logic                 req_ready_o,
    input  logic                 req_write_i,
    input  logic [REG_IDX_W-1:0] req_addr_i,
    input  logic [WORD_W-1:0]    req_wdata_i,
    output logic                 rsp_valid_o,
    output logic [WORD_W-1:0]    rsp_rdata_o
);
    localparam int unsigned DEPTH  = CHANNELS * CH_STRIDE;
    localparam int unsigned ADDR_W = $clog2(DEPTH);

    port_state_t s_d, s_q;

    logic              busy_w;
    logic [ADDR_W-1:0] ptr_w;
    logic [WORD_W-1:0] ram_rdata_w;
    logic [WORD_W-1:0] ctrl_view;

    logic accept, is_ctrl, is_data, in_range;
    logic ctrl_wr, data_wr, data_rd, data_eff;
    logic ram_we, ram_re, ptr_load, ptr_step;

    // Control readback image
    always_comb begin
        ctrl_view                = '0;
        ctrl_view[CTRL_BUSY_BIT] = busy_w;
        ctrl_view[CTRL_WDIR_BIT] = s_q.wdir;
        ctrl_view[CTRL_STEP_BIT] = s_q.step;
        ctrl_view[ADDR_W-1:0]    = ptr_w;
    end

    // Next-state computation
    always_comb begin
        accept   = req_valid_i && s_q.ready;
        is_ctrl  = (reg_idx_e'(req_addr_i) == REG_CTRL);
        is_data  = (reg_idx_e'(req_addr_i) == REG_DATA);
        in_range = (int'(ptr_w) < DEPTH);

        ctrl_wr  = accept && req_write_i && is_ctrl && !busy_w;
        data_wr  = accept && req_write_i && is_data && !busy_w && s_q.wdir;
        data_rd  = accept && !req_write_i && is_data && !busy_w && !s_q.wdir;
        data_eff = data_wr || data_rd;

        ram_we   = data_wr && in_range;
        ram_re   = data_rd && in_range;
        ptr_load = ctrl_wr && req_wdata_i[CTRL_LOAD_BIT];
        ptr_step = data_eff && s_q.step;

        s_d       = s_q;
        s_d.ready = 1'b1;
        if (ctrl_wr) begin
            s_d.wdir = req_wdata_i[CTRL_WDIR_BIT];
            s_d.step = req_wdata_i[CTRL_STEP_BIT];
        end
        s_d.rsp_valid    = accept && !req_write_i;
        s_d.rsp_from_ram = ram_re;
        s_d.rsp_reg      = (accept && !req_write_i && is_ctrl) ? ctrl_view : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q              <= '0;
            s_q.wdir         <= CTRL_RESET_VAL[CTRL_WDIR_BIT];
            s_q.step         <= CTRL_RESET_VAL[CTRL_STEP_BIT];
        end else begin
            s_q <= s_d;
        end
    end

    param_ptr_seq #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (ptr_load),
        .load_addr_i (req_wdata_i[ADDR_W-1:0]),
        .step_i      (ptr_step),
        .ptr_o       (ptr_w)
    );

    param_busy_timer #(
        .CYCLES (BUSY_CYCLES)
    ) u_busy (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (data_eff),
        .busy_o  (busy_w)
    );

    param_cfg_ram #(
        .DEPTH  (DEPTH),
        .WIDTH  (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (ram_we),
        .re_i    (ram_re),
        .addr_i  (ptr_w),
        .wdata_i (req_wdata_i),
        .rdata_o (ram_rdata_w)
    );

    assign req_ready_o = s_q.ready;
    assign rsp_valid_o = s_q.rsp_valid;
    assign rsp_rdata_o = s_q.rsp_from_ram ? ram_rdata_w : s_q.rsp_reg;

    // R11: an accepted read is answered in the next cycle
    assert_rsp_follows_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && !req_write_i) |=> rsp_valid_o);

    // R11: no response without an accepted read
    assert_no_rsp_otherwise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_valid_i && req_ready_o && !req_write_i) |=> !rsp_valid_o);

    // R8: any request during busy leaves the pointer in place
    assert_busy_freezes_ptr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && busy_w) |=> $stable(ptr_w));

    // R6: a matching data access with stepping on advances by one below the last word
    assert_step_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && !busy_w && (req_addr_i == 2'd1) && s_q.step
         && (req_write_i == s_q.wdir) && (int'(ptr_w) < DEPTH - 1))
        |=> (ptr_w == $past(ptr_w) + ADDR_W'(1)));

    // R9: a data access in the wrong direction does not raise busy
    assert_mismatch_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && !busy_w && (req_addr_i == 2'd1)
         && (req_write_i != s_q.wdir)) |=> !busy_w);

endmodule

// File: tb/param_ram_port_tb_top.sv
`timescale 1ns/1ps
module param_ram_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  idx = 2'd0;
    logic [31:0] wdata = '0;
    logic        ready;
    logic        rsp_v;
    logic [31:0] rsp_d;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic        got_v;
    logic [31:0] got_d;

    always #4 clk = ~clk;

    param_ram_port dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_valid_i (valid),
        .req_ready_o (ready),
        .req_write_i (wr),
        .req_addr_i  (idx),
        .req_wdata_i (wdata),
        .rsp_valid_o (rsp_v),
        .rsp_rdata_o (rsp_d)
    );

    // vector: {req[3:0], write, idx[1:0], pad, wdata[31:0], expected[31:0]}
    function automatic logic [71:0] mk(input int r, input bit w, input int i,
                                       input logic [31:0] wd, input logic [31:0] ex);
        return {4'(r), w, 2'(i), 1'b0, wd, ex};
    endfunction

    localparam int NV = 46;
    localparam logic [71:0] VEC [NV] = '{
        mk(1,  0, 0, 32'h0, 32'h0000_4000),        // R1 reset image
        mk(3,  1, 0, 32'h0000_6010, 32'h0),        // R3 load 16, write dir
        mk(3,  0, 0, 32'h0, 32'h0000_4010),        // R3 / R2 strobe reads 0
        mk(4,  1, 1, 32'h0000_00A1, 32'h0),        // R4 store at 16
        mk(6,  0, 0, 32'h0, 32'h0000_4010),        // R6 stepping off holds
        mk(6,  1, 0, 32'h0000_7005, 32'h0),        // R6 load 5, step on
        mk(12, 1, 1, 32'h1111_1111, 32'h0),        // R12 channel 0 slot 5
        mk(6,  0, 0, 32'h0, 32'h0000_5006),        // R6 advanced
        mk(12, 1, 0, 32'h0000_7015, 32'h0),        // R12 channel 1 slot 5
        mk(12, 1, 1, 32'h2222_2222, 32'h0),
        mk(5,  1, 0, 32'h0000_3005, 32'h0),        // R5 read dir, step, load 5
        mk(12, 0, 1, 32'h0, 32'h1111_1111),        // R12 no alias
        mk(6,  0, 0, 32'h0, 32'h0000_1006),        // R6 read also steps
        mk(5,  1, 0, 32'h0000_2015, 32'h0),
        mk(5,  0, 1, 32'h0, 32'h2222_2222),        // R5
        mk(6,  0, 1, 32'h0, 32'h2222_2222),        // R6 no step repeats word
        mk(6,  0, 0, 32'h0, 32'h0000_0015),
        mk(9,  1, 1, 32'h0000_DEAD, 32'h0),        // R9 write in read dir
        mk(9,  0, 1, 32'h0, 32'h2222_2222),        // R9 word untouched
        mk(9,  1, 0, 32'h0000_6010, 32'h0),
        mk(9,  0, 1, 32'h0, 32'h0000_0000),        // R9 read in write dir -> 0
        mk(9,  0, 0, 32'h0, 32'h0000_4010),        // R9 pointer kept
        mk(2,  1, 0, 32'h8000_5000, 32'h0),        // R2 bit31 write, no load
        mk(2,  0, 0, 32'h0, 32'h0000_5010),        // R2 / R3 pointer kept
        mk(11, 1, 2, 32'hFFFF_FFFF, 32'h0),        // R11 reserved write
        mk(11, 0, 2, 32'h0, 32'h0000_0000),        // R11 reserved read
        mk(11, 0, 3, 32'h0, 32'h0000_0000),
        mk(11, 0, 0, 32'h0, 32'h0000_5010),        // R11 control unchanged
        mk(4,  1, 0, 32'h0000_2010, 32'h0),
        mk(4,  0, 1, 32'h0, 32'h0000_00A1),        // R4 word 16
        mk(6,  1, 0, 32'h0000_709F, 32'h0),        // R6 load 159
        mk(6,  1, 1, 32'h0000_9F9F, 32'h0),
        mk(6,  0, 0, 32'h0, 32'h0000_5000),        // R6 wrap to 0
        mk(6,  1, 1, 32'h00C0_FFEE, 32'h0),        // word 0
        mk(6,  0, 0, 32'h0, 32'h0000_5001),
        mk(6,  1, 0, 32'h0000_309F, 32'h0),
        mk(6,  0, 1, 32'h0, 32'h0000_9F9F),
        mk(6,  0, 0, 32'h0, 32'h0000_1000),        // R6 read wrap
        mk(10, 1, 0, 32'h0000_70C8, 32'h0),        // R10 load 200
        mk(10, 1, 1, 32'h0000_0BAD, 32'h0),
        mk(10, 0, 0, 32'h0, 32'h0000_5000),        // R10 steps to 0
        mk(10, 1, 0, 32'h0000_30C8, 32'h0),
        mk(10, 0, 1, 32'h0, 32'h0000_0000),        // R10 read 0
        mk(10, 0, 0, 32'h0, 32'h0000_1000),
        mk(10, 1, 0, 32'h0000_2000, 32'h0),
        mk(10, 0, 1, 32'h0, 32'h00C0_FFEE)         // R10 drop did not land
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with the response.
    task automatic req(input bit w, input int i, input logic [31:0] d);
        valid = 1'b1;
        wr    = w;
        idx   = 2'(i);
        wdata = d;
        @(negedge clk);
        got_v = rsp_v;
        got_d = rsp_d;
    endtask

    task automatic idle(input int n);
        valid = 1'b0;
        wr    = 1'b0;
        wdata = '0;
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk_read(input string r, input logic [31:0] exp);
        check(got_v === 1'b1, {r, " rsp_valid"}, 32'(got_v), 32'h1);
        check(got_d === exp, r, got_d, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        check(ready === 1'b0, "R1 ready in reset", 32'(ready), 32'h0);
        check(rsp_v === 1'b0, "R1 rsp in reset", 32'(rsp_v), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready === 1'b1, "R1 ready after reset", 32'(ready), 32'h1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [71:0] e;
            e = VEC[v];
            req(e[67], int'(e[66:65]), e[63:32]);
            if (e[67]) begin
                check(got_v === 1'b0, $sformatf("R%0d write no rsp #%0d", e[71:68], v),
                      32'(got_v), 32'h0);
            end else begin
                chk_read($sformatf("R%0d vec #%0d", e[71:68], v), e[31:0]);
            end
            idle(2);
        end

        // R8: commands inside the busy window are dropped, no retrigger
        req(1, 0, 32'h0000_7032); idle(2);
        req(1, 1, 32'h0000_0055);
        req(1, 0, 32'h0000_705A);
        req(1, 1, 32'h0000_0066);
        req(0, 0, 32'h0);
        chk_read("R8 ctrl write and data write dropped while busy", 32'h0000_5033);
        idle(2);

        // R7: busy visible for exactly two cycles
        req(1, 1, 32'h0000_0077);
        req(0, 0, 32'h0); chk_read("R7 busy cycle 1", 32'h8000_5034);
        req(0, 0, 32'h0); chk_read("R7 busy cycle 2", 32'h8000_5034);
        req(0, 0, 32'h0); chk_read("R7 busy cleared", 32'h0000_5034);
        idle(1);
        check(rsp_v === 1'b0, "R11 single-cycle response", 32'(rsp_v), 32'h0);
        idle(1);

        // R8: read during busy returns 0 and does not step
        req(1, 0, 32'h0000_3032); idle(2);
        req(0, 1, 32'h0); chk_read("R5 read word 50", 32'h0000_0055);
        req(0, 1, 32'h0); chk_read("R8 read while busy", 32'h0000_0000);
        idle(2);
        req(0, 1, 32'h0); chk_read("R8 pointer not stepped, word 51", 32'h0000_0077);
        idle(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule